// File: doc/BRIEF.md
# Subtractive GCD Engine with Quad-Step Shortcut

This block computes the greatest common divisor of two unsigned W-bit operands by repeated subtraction. A caller waits for `ready_o`, presents both operands together with a one-cycle `start_i`, and later receives the result on `result_o` together with a single-cycle `done_o` pulse.

Beside the ordinary subtract datapath sits a shortcut unit. Each iteration it forms x minus four times y, one bit wider than needed so that an underflow shows up as a negative value. When that difference is strictly positive, x takes it in one cycle, which saves several ordinary steps. Otherwise the ordinary step runs in that cycle. The cycles that take the shortcut are flagged on `fast_o`. An operand of zero ends the computation on the first iteration cycle.

Top module: `gcd_cc_unit`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `fast_o` is 0.
- R2: For two nonzero operands, `result_o` at the `done_o` pulse equals their greatest common divisor.
- R3: If either operand is zero, `result_o` equals the other operand (zero when both are zero), and `done_o` rises one cycle after the start is accepted.
- R4: In an iteration cycle where x > 4·y, the next x is x − 4·y, y is kept, and `fast_o` is 1 in that cycle. The number of such cycles per run matches a model that applies this rule before any other.
- R5: In an iteration cycle where x and y are nonzero, differ, and x ≤ 4·y, the larger operand is reduced by the smaller one and `fast_o` is 0.
- R6: Let N be the number of iteration steps that change x or y. `done_o` is seen N+1 cycles after the clock edge that accepts the start.
- R7: `start_i` and operand changes while `ready_o` is 0 have no effect on the running computation.
- R8: `done_o` lasts exactly one cycle. `result_o` changes only on a cycle in which `done_o` is raised, and holds its value until the next result.
- R9: `ready_o` falls on the edge that accepts a start, stays 0 while the computation runs, and is 1 again in the cycle in which `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin; taken only while ready_o is 1 |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| ready_o | output | 1 | Idle and able to accept a start |
| result_o | output | W | Greatest common divisor of the last run |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| fast_o | output | 1 | The current iteration takes the quad-step shortcut |

## Verification
The checker assumes that `start_i` matters only while `ready_o` is 1. It also assumes that reset is held for a few clock edges before the first check, so that the stability checks never compare against values from before reset. The bench drives every input on the falling edge. It raises `start_i` for a single cycle once it has seen `ready_o`, and it pulses `start_i` during a run only in the tests that check that such a pulse is ignored. With W=5, the sweep covers every operand pair, including all pairs with a zero operand.

// File: rtl/gcd_cc_pkg.sv
package gcd_cc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gcd_state_e;
endpackage

// File: rtl/gcd_cc_base.sv
// Ordinary step: the larger operand is reduced by the smaller one.
module gcd_cc_base #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] x_nx_o,
  output logic [W-1:0] y_nx_o
);
  logic x_gt;

  always_comb begin
    x_gt   = (x_i > y_i);
    x_nx_o = x_gt ? (x_i - y_i) : x_i;
    y_nx_o = x_gt ? y_i : (y_i - x_i);
  end
endmodule

// File: rtl/gcd_cc_fast.sv
// Shortcut step: take x - 4y when that difference is strictly positive.
module gcd_cc_fast #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         hit_o,
  output logic [W-1:0] x_nx_o
);
  localparam int TW = W + 3;  // holds 4*y plus a sign bit
  logic [TW-1:0] diff;

  always_comb begin
    diff   = {3'b000, x_i} - {1'b0, y_i, 2'b00};
    hit_o  = !diff[TW-1] && (diff != '0);
    x_nx_o = diff[W-1:0];
  end
endmodule

// File: rtl/gcd_cc_unit.sv
module gcd_cc_unit
  import gcd_cc_pkg::*;
#(
  parameter int W       = 8,
  parameter bit FAST_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         ready_o,
  output logic [W-1:0] result_o,
  output logic         done_o,
  output logic         fast_o
);
  gcd_state_e  state_q, state_d;
  logic [W-1:0] x_q, x_d, y_q, y_d;
  logic [W-1:0] res_q, res_d;
  logic         done_q, done_d;
  logic         x_en, res_en;

  logic [W-1:0] base_x, base_y;
  logic         cc_hit;
  logic [W-1:0] cc_x;
  logic         finish;

  gcd_cc_base #(.W(W)) base_i (
    .x_i(x_q), .y_i(y_q), .x_nx_o(base_x), .y_nx_o(base_y)
  );

  generate
    if (FAST_EN) begin : g_fast
      gcd_cc_fast #(.W(W)) fast_i (
        .x_i(x_q), .y_i(y_q), .hit_o(cc_hit), .x_nx_o(cc_x)
      );
    end else begin : g_nofast
      assign cc_hit = 1'b0;
      assign cc_x   = x_q;
    end
  endgenerate

  // next state
  always_comb begin
    state_d = state_q;
    x_d     = x_q;
    y_d     = y_q;
    res_d   = res_q;
    done_d  = 1'b0;
    x_en    = 1'b0;
    res_en  = 1'b0;
    finish  = (x_q == '0) || (y_q == '0) || (x_q == y_q);
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          x_en    = 1'b1;
          x_d     = a_i;
          y_d     = b_i;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (finish) begin
          res_en  = 1'b1;
          res_d   = x_q | y_q;  // zero operand -> the other one; equal -> x
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          x_en = 1'b1;
          if (cc_hit) begin
            x_d = cc_x;
          end else begin
            x_d = base_x;
            y_d = base_y;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      res_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (res_en) res_q <= res_d;
      if (x_en) begin
        x_q <= x_d;
        y_q <= y_d;
      end
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign result_o = res_q;
  assign done_o   = done_q;
  assign fast_o   = (state_q == ST_RUN) && !finish && cc_hit;
endmodule

// File: rtl/gcd_cc_chk.sv
module gcd_cc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         ready_o,
  input logic [W-1:0] result_o,
  input logic         done_o,
  input logic         fast_o
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(result_o)));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> !ready_o);

  assert_ready_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);

  assert_fast_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |-> !ready_o);

  assert_fast_not_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |=> !done_o);
endmodule

bind gcd_cc_unit gcd_cc_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .result_o(result_o), .done_o(done_o), .fast_o(fast_o)
);

// File: tb/gcd_cc_unit_tb_top.sv
module gcd_cc_unit_tb_top;
  localparam int W = 5;
  localparam int N = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] a_i, b_i;
  logic         ready_o, done_o, fast_o;
  logic [W-1:0] result_o;

  int total;
  int bad;

  gcd_cc_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .ready_o(ready_o), .result_o(result_o), .done_o(done_o), .fast_o(fast_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int euclid(input int a, input int b);
    int p = a;
    int q = b;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  // one run; busy_poke pulses start with other operands mid-run (R7)
  task automatic run_pair(input int a, input int b, input bit busy_poke);
    int x = a;
    int y = b;
    int steps = 0;
    int fast_exp = 0;
    int lat = 0;
    int fast_cnt = 0;
    int exp_res;
    bit zero_case;
    zero_case = (a == 0) || (b == 0);
    if (zero_case) exp_res = a | b;
    else exp_res = euclid(a, b);
    if (!zero_case) begin
      while (x != y) begin
        if (x > 4 * y) begin x = x - 4 * y; fast_exp++; end
        else if (x > y) x = x - y;
        else y = y - x;
        steps++;
      end
    end
    while (!ready_o) @(negedge clk);
    a_i = W'(a); b_i = W'(b); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!ready_o, "R9 busy after accept", ready_o, 0);
    while (!done_o && lat < 1000) begin
      fast_cnt += fast_o;
      if (busy_poke && lat == 0) begin
        a_i = W'(a + 3); b_i = W'(b + 1); start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    if (zero_case) begin
      check(result_o == W'(exp_res), "R3 zero operand result", result_o, exp_res);
      check(lat == 1, "R3 zero operand latency", lat, 1);
    end else begin
      check(result_o == W'(exp_res), busy_poke ? "R7 result with busy start" : "R2 gcd result",
            result_o, exp_res);
      check(fast_cnt == fast_exp, "R4 fast step count", fast_cnt, fast_exp);
      if (fast_exp == 0)
        check(lat == steps + 1, "R5 plain subtract latency", lat, steps + 1);
      else
        check(lat == steps + 1, "R6 latency", lat, steps + 1);
    end
    check(ready_o, "R9 ready at done", ready_o, 1);
    @(negedge clk);
    check(!done_o, "R8 done one cycle", done_o, 0);
    check(result_o == W'(exp_res), "R8 result held", result_o, exp_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    start_i = 1'b0; a_i = '0; b_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o, "R1 ready after reset", ready_o, 1);
    check(!done_o, "R1 done after reset", done_o, 0);
    check(!fast_o, "R1 fast after reset", fast_o, 0);
    // directed corner cases
    run_pair(31, 1, 1'b0);   // R4 long fast chain
    run_pair(0, 0, 1'b0);    // R3 both zero
    run_pair(0, 17, 1'b0);   // R3
    run_pair(20, 5, 1'b0);   // R4 boundary: x == 4y not fast
    run_pair(21, 5, 1'b0);   // R4 x > 4y
    run_pair(12, 18, 1'b0);  // R5 plain
    run_pair(30, 7, 1'b1);   // R7
    run_pair(9, 6, 1'b1);    // R7
    // exhaustive sweep
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++)
        run_pair(a, b, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule